// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Register Unit

This unit holds the two 9-bit thresholds that the flag logic of a 512-word FIFO compares against its fill level: one for the almost-empty flag and one for the almost-full flag. Each threshold is split across two byte-wide slots, an 8-bit low byte and a 1-bit high part. That gives four slots behind a single data port. A 2-bit slot pointer picks the slot for each access and steps to the next slot after every access. Software never addresses a slot directly. It writes or reads a run of bytes in the fixed order low-empty, high-empty, low-full, high-full, and the run wraps after the fourth byte.

The FIFO's load pin has two meanings. The value it holds during reset selects the unit's mode. If the pin is low during reset, the unit is programmable. After reset the same pin acts as a strobe: with the write enable it loads the FIFO data input into a slot, and with the read enable it copies a slot onto the data output. If the pin is high during reset, the thresholds stay at their reset value of 7 until the next reset. The unit runs on one clock, which is the read and write clock tied together. The assembled thresholds go straight to the flag logic.

Top module: `ofs_flag_regs`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `empty_ofs` and `full_ofs` both read 7. The slot pointer is at slot 0 and `dout` reads 0.
- R2: The value of `ld` in the last cycle with `rst` high sets the mode. If it was 0 the unit is programmable; if it was 1, loading and readback are disabled until the next reset.
- R3: In programmable mode, a rising edge with `ld`=1 and `wr_en`=1 stores `din` into the slot the pointer selects. The new threshold appears on `empty_ofs`/`full_ofs` after that same edge. `empty_ofs` is {slot1[0], slot0} and `full_ofs` is {slot3[0], slot2}.
- R4: A store to a high slot (slot 1 or 3) keeps only `din[0]`, and that bit becomes bit 8 of the threshold. `din[8:1]` is discarded.
- R5: In programmable mode, a rising edge with `ld`=1, `rd_en`=1 and `wr_en`=0 places the selected slot's contents on `dout[7:0]`, with `dout[8]`=0. A high slot reads back with bits 8:1 zero. `dout` holds its value in every other cycle.
- R6: If `ld`, `wr_en` and `rd_en` are all 1 in the same cycle, only the store happens. `dout` does not change and the pointer advances once.
- R7: The pointer visits slots 0, 1, 2, 3 and then wraps to 0. It advances by exactly one on each store or readback, and not otherwise.
- R8: In disabled mode, `ld` with either enable leaves `empty_ofs`, `full_ofs`, `dout` and the pointer unchanged.
- R9: With `ld`=0, `wr_en` and `rd_en` affect neither the thresholds, `dout`, nor the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared read/write clock |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | Mode select during reset; load strobe afterwards |
| wr_en | input | 1 | Write enable of the FIFO input port |
| rd_en | input | 1 | Read enable of the FIFO output port |
| din | input | 9 | FIFO data input |
| dout | output | 9 | Readback data (the FIFO output register path) |
| empty_ofs | output | 9 | Almost-empty threshold to the flag logic |
| full_ofs | output | 9 | Almost-full threshold to the flag logic |

## Verification
The pointer cannot be seen directly, so a pointer that slips or advances twice shows up one access later. The following store lands in the wrong half of a threshold, or the following readback returns a neighbouring slot. The tests therefore mix stores and readbacks and compare every byte. A wrongly captured mode shows on the first strobed access after reset: the thresholds either move when they must stay at 7, or stay at 7 when they must move. A fault in the high-part masking shows in bit 8 of a threshold, or in the upper bits of a readback, right after the edge that caused it.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    // Slot order walked by the auto-incrementing pointer
    typedef enum logic [1:0] {
        SLOT_EMPTY_LO = 2'd0,
        SLOT_EMPTY_HI = 2'd1,
        SLOT_FULL_LO  = 2'd2,
        SLOT_FULL_HI  = 2'd3
    } slot_e;

    localparam int NUM_SLOTS = 4;

endpackage

// File: rtl/ofs_mode_latch.sv
module ofs_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic ld,
    output logic prog_en
);

    typedef struct packed {
        logic prog;
    } mode_t;

    mode_t st_d, st_q;

    // Mode follows the dual-purpose pin while reset is held;
    // the value in the final reset cycle is kept.
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.prog = ~ld;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign prog_en = st_q.prog;

endmodule

// File: rtl/ofs_slot_ptr.sv
module ofs_slot_ptr #(
    parameter int NSLOT = 4,
    localparam int PTR_W = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_t;

    ptr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.ptr = '0;
        end else if (step) begin
            if (st_q.ptr == PTR_W'(NSLOT - 1)) begin
                st_d.ptr = '0;
            end else begin
                st_d.ptr = st_q.ptr + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank #(
    parameter int NSLOT   = 4,
    parameter int OFS_W   = 9,
    parameter int LO_W    = 8,
    parameter int DEF_OFS = 7,
    localparam int PTR_W  = $clog2(NSLOT),
    localparam int HI_W   = OFS_W - LO_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [PTR_W-1:0]           sel,
    input  logic [LO_W-1:0]            wdata,
    output logic [NSLOT-1:0][LO_W-1:0] slots
);

    localparam logic [LO_W-1:0] HI_MASK = LO_W'((1 << HI_W) - 1);
    localparam logic [LO_W-1:0] LO_DEF  = LO_W'(DEF_OFS);
    localparam logic [LO_W-1:0] HI_DEF  = LO_W'(DEF_OFS >> LO_W) & HI_MASK;

    // Even slots hold low bytes, odd slots hold the narrow high parts
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        localparam bit              IS_HI = (i % 2) == 1;
        localparam logic [LO_W-1:0] MASK  = IS_HI ? HI_MASK : {LO_W{1'b1}};
        localparam logic [LO_W-1:0] RSTV  = IS_HI ? HI_DEF : LO_DEF;

        typedef struct packed {
            logic [LO_W-1:0] val;
        } slot_t;

        slot_t st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (rst) begin
                st_d.val = RSTV;
            end else if (wr && (sel == PTR_W'(i))) begin
                st_d.val = wdata & MASK;
            end
        end

        always_ff @(posedge clk) begin
            st_q <= st_d;
        end

        assign slots[i] = st_q.val;
    end

endmodule

// File: rtl/ofs_flag_regs.sv
module ofs_flag_regs #(
    parameter int OFS_W   = 9,
    parameter int LO_W    = 8,
    parameter int DEF_OFS = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] din,
    output logic [OFS_W-1:0] dout,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs
);

    import ofs_pkg::*;

    localparam int NSLOT = NUM_SLOTS;
    localparam int PTR_W = $clog2(NSLOT);
    localparam int HI_W  = OFS_W - LO_W;

    logic                       prog_en;
    logic [PTR_W-1:0]           slot_ptr;
    logic [NSLOT-1:0][LO_W-1:0] slots;
    logic                       do_store;
    logic                       do_fetch;

    ofs_mode_latch u_mode (
        .clk     (clk),
        .rst     (rst),
        .ld      (ld),
        .prog_en (prog_en)
    );

    // Store wins when both enables are present
    assign do_store = prog_en && ld && wr_en;
    assign do_fetch = prog_en && ld && rd_en && !wr_en;

    ofs_slot_ptr #(.NSLOT(NSLOT)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .step (do_store || do_fetch),
        .ptr  (slot_ptr)
    );

    ofs_reg_bank #(
        .NSLOT   (NSLOT),
        .OFS_W   (OFS_W),
        .LO_W    (LO_W),
        .DEF_OFS (DEF_OFS)
    ) u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr    (do_store),
        .sel   (slot_ptr),
        .wdata (din[LO_W-1:0]),
        .slots (slots)
    );

    typedef struct packed {
        logic [OFS_W-1:0] rdata;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (rst) begin
            rb_d.rdata = '0;
        end else if (do_fetch) begin
            rb_d.rdata = OFS_W'(slots[slot_ptr]);
        end
    end

    always_ff @(posedge clk) begin
        rb_q <= rb_d;
    end

    assign dout      = rb_q.rdata;
    assign empty_ofs = {slots[SLOT_EMPTY_HI][HI_W-1:0], slots[SLOT_EMPTY_LO]};
    assign full_ofs  = {slots[SLOT_FULL_HI][HI_W-1:0], slots[SLOT_FULL_LO]};

endmodule

// File: rtl/ofs_flag_regs_chk.sv
module ofs_flag_regs_chk #(
    parameter int OFS_W   = 9,
    parameter int DEF_OFS = 7,
    parameter int PTR_W   = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ld,
    input logic             wr_en,
    input logic             rd_en,
    input logic [OFS_W-1:0] dout,
    input logic [OFS_W-1:0] empty_ofs,
    input logic [OFS_W-1:0] full_ofs,
    input logic             prog_en,
    input logic [PTR_W-1:0] slot_ptr
);

    logic acc;
    assign acc = prog_en && ld && (wr_en || rd_en);

    assert_reset_defaults_R1: assert property (@(posedge clk)
        $fell(rst) |-> (empty_ofs == OFS_W'(DEF_OFS)) && (full_ofs == OFS_W'(DEF_OFS))
                       && (dout == '0) && (slot_ptr == '0));

    assert_ptr_step_R7: assert property (@(posedge clk) disable iff (rst)
        acc |=> slot_ptr == PTR_W'($past(slot_ptr) + PTR_W'(1)));

    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(slot_ptr));

    assert_fetch_no_change_R5: assert property (@(posedge clk) disable iff (rst)
        !(acc && wr_en) |=> $stable(empty_ofs) && $stable(full_ofs));

    assert_store_hides_fetch_R6: assert property (@(posedge clk) disable iff (rst)
        (ld && wr_en) |=> $stable(dout));

    assert_disabled_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !prog_en |=> $stable(empty_ofs) && $stable(full_ofs) && $stable(dout));

    assert_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(empty_ofs) && $stable(full_ofs) && $stable(dout));

endmodule

bind ofs_flag_regs ofs_flag_regs_chk #(
    .OFS_W   (OFS_W),
    .DEF_OFS (DEF_OFS),
    .PTR_W   (PTR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld        (ld),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .dout      (dout),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs),
    .prog_en   (prog_en),
    .slot_ptr  (slot_ptr)
);

// File: tb/tb_ofs_flag_regs.sv
`timescale 1ns/1ps
module tb_ofs_flag_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [8:0] din = '0;
    logic [8:0] dout, empty_ofs, full_ofs;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ofs_flag_regs dut (
        .clk(clk), .rst(rst), .ld(ld), .wr_en(wr_en), .rd_en(rd_en),
        .din(din), .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    task automatic chk(input string req, input string what, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Hold reset for two cycles with the given pin level
    task automatic do_reset(input logic ld_lvl);
        @(negedge clk);
        rst = 1'b1; ld = ld_lvl; wr_en = 0; rd_en = 0;
        repeat (2) @(negedge clk);
        rst = 1'b0; ld = 1'b0;
        @(posedge clk); #1;
    endtask

    // One cycle of stimulus, sampled 1 ns after the capturing edge
    task automatic cyc(input logic l, input logic w, input logic r, input logic [8:0] d);
        @(negedge clk);
        ld = l; wr_en = w; rd_en = r; din = d;
        @(posedge clk); #1;
        @(negedge clk);
        ld = 0; wr_en = 0; rd_en = 0;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1", "empty_ofs", empty_ofs, 9'h007);
        chk("R1", "full_ofs", full_ofs, 9'h007);
        chk("R1", "dout", dout, 9'h000);
        cyc(1, 0, 1, 9'h0);
        chk("R1", "first readback slot0", dout, 9'h007);
        cyc(1, 0, 1, 9'h0);
        chk("R1", "second readback slot1", dout, 9'h000);
    endtask

    task automatic t_load();
        do_reset(1'b0);
        cyc(1, 1, 0, 9'h05A);
        chk("R3", "empty low byte", empty_ofs, 9'h05A);
        cyc(1, 1, 0, 9'h1FF);
        chk("R4", "empty high bit", empty_ofs, 9'h15A);
        cyc(1, 1, 0, 9'h033);
        chk("R3", "full low byte", full_ofs, 9'h033);
        cyc(1, 1, 0, 9'h002);
        chk("R4", "full high keeps bit0", full_ofs, 9'h033);
        chk("R3", "empty untouched", empty_ofs, 9'h15A);
    endtask

    task automatic t_readback();
        cyc(1, 0, 1, 9'h0);
        chk("R5", "read slot0", dout, 9'h05A);
        cyc(1, 0, 1, 9'h0);
        chk("R5", "read slot1 upper zero", dout, 9'h001);
        cyc(0, 0, 0, 9'h0);
        chk("R5", "dout holds", dout, 9'h001);
        cyc(1, 0, 1, 9'h0);
        chk("R7", "read slot2", dout, 9'h033);
        cyc(1, 0, 1, 9'h0);
        chk("R7", "read slot3", dout, 9'h000);
        chk("R5", "readback leaves empty", empty_ofs, 9'h15A);
    endtask

    task automatic t_wrap();
        cyc(1, 1, 0, 9'h0A5);
        chk("R7", "wrap store to slot0", empty_ofs, 9'h1A5);
        chk("R7", "full intact", full_ofs, 9'h033);
    endtask

    task automatic t_both();
        cyc(1, 1, 1, 9'h000);
        chk("R6", "store slot1", empty_ofs, 9'h0A5);
        chk("R6", "dout unchanged", dout, 9'h000);
        cyc(1, 0, 1, 9'h0);
        chk("R6", "single advance to slot2", dout, 9'h033);
    endtask

    task automatic t_nostrobe();
        cyc(0, 1, 0, 9'h1FF);
        chk("R9", "wr without ld empty", empty_ofs, 9'h0A5);
        chk("R9", "wr without ld full", full_ofs, 9'h033);
        cyc(0, 0, 1, 9'h0);
        chk("R9", "rd without ld dout", dout, 9'h033);
        cyc(1, 0, 0, 9'h0);
        cyc(1, 0, 1, 9'h0);
        chk("R9", "pointer still slot3", dout, 9'h000);
        cyc(1, 0, 1, 9'h0);
        chk("R7", "wrap read slot0", dout, 9'h0A5);
    endtask

    task automatic t_disabled();
        do_reset(1'b1);
        cyc(1, 1, 0, 9'h155);
        chk("R8", "store ignored empty", empty_ofs, 9'h007);
        chk("R8", "store ignored full", full_ofs, 9'h007);
        cyc(1, 0, 1, 9'h0);
        chk("R8", "readback ignored", dout, 9'h000);
        do_reset(1'b0);
        cyc(1, 1, 0, 9'h0C3);
        chk("R2", "programmable after low reset", empty_ofs, 9'h0C3);
    endtask

    initial begin
        t_reset();
        t_load();
        t_readback();
        t_wrap();
        t_both();
        t_nostrobe();
        t_disabled();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule